// File: doc/BRIEF.md
# Tributary AIS Detector (DS1 / E1)

This block watches a single tributary bit stream, running at either the DS1 or the E1 rate, and decides whether it carries an alarm indication signal. An all-ones stream is the signature of AIS. The block therefore retimes the incoming data on a chosen clock edge and counts the zero bits in fixed, back-to-back windows. From those counts it decides whether the alarm is present or absent.

DS1 uses one long window, and its verdict takes effect at the end of that window. E1 uses shorter windows with hysteresis. Two consecutive windows must agree before the status changes in either direction. Every change of status, whether set or clear, raises a sticky change flag. Software clears the flag with a strobe. The flag drives an interrupt output unless a mask bit blocks it.

The window counters run on the tributary clock. The mode input chooses the window length and the zero threshold. Changing the mode restarts the current window and clears the E1 history.

Top module: `ais_det_top`

## Requirements
- R1: When `edge_sel` is 1, data is sampled on the rising clock edge. When it is 0, data is sampled on the falling edge. A zero that lasts only around one kind of edge is counted only when that edge is selected.
- R2: When `mode_sel` is 0 (DS1), `ais` is set when a window of `DS1_WIN` clock periods (default 8192) holds fewer than `DS1_THR` zeros (default 9).
- R3: In DS1 mode, `ais` is cleared at the end of any window that holds `DS1_THR` or more zeros. `ais` changes only after a window boundary.
- R4: When `mode_sel` is 1 (E1), `ais` is set only when two consecutive windows of `E1_WIN` bits (default 512) each hold fewer than `E1_THR` zeros (default 3). A single such window leaves `ais` unchanged.
- R5: In E1 mode, `ais` is cleared only when two consecutive windows each hold `E1_THR` or more zeros. A single such window leaves `ais` set.
- R6: Any change of `ais` sets `delta`. `delta` then stays at 1 until a cycle with `rd_clr` high clears it.
- R7: When `ais` changes in the same cycle that `rd_clr` would clear `delta`, the change wins and `delta` stays at 1.
- R8: `irq` is 1 exactly when `delta` is 1 and `mask` is 0. `irq` is registered, so a change of `mask` takes effect one clock later.
- R9: A change of `mode_sel` restarts the window and zero counters and discards the E1 record of the previous window.
- R10: While `rst` is high and after it falls, `ais`, `delta` and `irq` are 0 until a window result changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tributary clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_sel | input | 1 | 1 selects the rising edge for retiming, 0 selects the falling edge |
| mode_sel | input | 1 | 0 selects DS1 windowing, 1 selects E1 windowing |
| din | input | 1 | Tributary data bit |
| rd_clr | input | 1 | Clears the change flag |
| mask | input | 1 | 1 blocks the interrupt |
| ais | output | 1 | Current AIS status |
| delta | output | 1 | Sticky flag for a change of AIS status |
| irq | output | 1 | Interrupt, the change flag gated by the mask |

## Verification
In DS1 mode, the bench drives windows that hold 0, 8, 9 and many zeros, so that the result on either side of the threshold is pinned down. In E1 mode, a sequence of windows with 1 to 4 zeros separates a single agreeing window from two in a row, in both the set and the clear direction. A history seeded before a mode toggle shows whether that toggle really discards it. Zero pulses placed only around the falling edge tell the two retiming edges apart. Strobe pulses, the mask, and a strobe timed to coincide with a status change exercise holding, clearing, gating and priority of the change flag.

// File: rtl/ais_det_pkg.sv
package ais_det_pkg;
  typedef enum logic {
    MODE_DS1 = 1'b0,
    MODE_E1  = 1'b1
  } trib_mode_e;
endpackage

// File: rtl/ais_retime.sv
module ais_retime (
  input  logic clk,
  input  logic rst,
  input  logic edge_sel,
  input  logic din,
  output logic dout
);
  logic smp_rise;
  logic smp_fall;

  always_ff @(posedge clk) begin
    if (rst) smp_rise <= 1'b1;
    else     smp_rise <= din;
  end

  always_ff @(negedge clk) begin
    if (rst) smp_fall <= 1'b1;
    else     smp_fall <= din;
  end

  assign dout = edge_sel ? smp_rise : smp_fall;
endmodule

// File: rtl/ais_zwin.sv
module ais_zwin #(
  parameter int DS1_WIN = 8192,
  parameter int DS1_THR = 9,
  parameter int E1_WIN  = 512,
  parameter int E1_THR  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic e1,
  input  logic restart,
  input  logic rt_bit,
  output logic win_end,
  output logic win_enough
);
  localparam int WMAX = (DS1_WIN > E1_WIN) ? DS1_WIN : E1_WIN;
  localparam int TMAX = (DS1_THR > E1_THR) ? DS1_THR : E1_THR;
  localparam int CW   = $clog2(WMAX);
  localparam int ZW   = $clog2(TMAX + 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_last;
  logic [ZW-1:0] zcnt_q;
  logic [ZW-1:0] zcnt_n;
  logic [ZW-1:0] thr;
  logic          z_inc;
  logic          at_last;

  always_comb begin
    pos_last = e1 ? CW'(E1_WIN - 1) : CW'(DS1_WIN - 1);
    thr      = e1 ? ZW'(E1_THR) : ZW'(DS1_THR);
    z_inc    = !rt_bit && (zcnt_q < thr);
    zcnt_n   = zcnt_q + ZW'(z_inc);
    at_last  = (pos_q == pos_last);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos_q      <= '0;
      zcnt_q     <= '0;
      win_end    <= 1'b0;
      win_enough <= 1'b0;
    end else begin
      win_end <= at_last;
      if (at_last) begin
        win_enough <= (zcnt_n >= thr);
        pos_q      <= '0;
        zcnt_q     <= '0;
      end else begin
        pos_q  <= pos_q + 1'b1;
        zcnt_q <= zcnt_n;
      end
    end
  end

  // R2: the zero counter never passes the active threshold
  p_zcnt_sat_r2: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (zcnt_q <= thr));

  // R9: a mode change leaves a fresh window behind
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pos_q == '0) && (zcnt_q == '0) && !win_end);
endmodule

// File: rtl/ais_judge.sv
module ais_judge (
  input  logic clk,
  input  logic rst,
  input  logic e1,
  input  logic restart,
  input  logic win_end,
  input  logic win_enough,
  output logic ais
);
  logic hist_v;
  logic hist_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      ais      <= 1'b0;
      hist_v   <= 1'b0;
      hist_low <= 1'b0;
    end else if (restart) begin
      hist_v   <= 1'b0;
      hist_low <= 1'b0;
    end else if (win_end) begin
      if (!e1) begin
        ais <= !win_enough;
      end else begin
        if (!win_enough && hist_v && hist_low)      ais <= 1'b1;
        else if (win_enough && hist_v && !hist_low) ais <= 1'b0;
        hist_v   <= 1'b1;
        hist_low <= !win_enough;
      end
    end
  end

  // R3: the status only moves just after a window has closed
  p_win_only_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(ais) |-> $past(win_end));

  // R4: in E1 a set needs a low window before the current one
  p_e1_pair_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(ais) && $past(e1)) |-> $past(hist_v && hist_low));

  // R5: in E1 a clear needs a high window before the current one
  p_e1_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ais) && $past(e1)) |-> $past(hist_v && !hist_low));
endmodule

// File: rtl/ais_evt.sv
module ais_evt (
  input  logic clk,
  input  logic rst,
  input  logic ais_in,
  input  logic rd_clr,
  input  logic mask,
  output logic delta,
  output logic irq
);
  logic ais_d;
  logic delta_n;

  always_comb begin
    if (ais_in != ais_d) delta_n = 1'b1;
    else if (rd_clr)     delta_n = 1'b0;
    else                 delta_n = delta;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ais_d <= 1'b0;
      delta <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ais_d <= ais_in;
      delta <= delta_n;
      irq   <= delta_n && !mask;
    end
  end

  // R6: the flag holds until a clear strobe
  p_delta_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (delta && !rd_clr) |=> delta);

  // R7: a status change sets the flag even under a clear strobe
  p_chg_wins_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ais_in) |=> delta);

  // R8: a set mask blocks the interrupt one cycle later
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq);
endmodule

// File: rtl/ais_det_top.sv
module ais_det_top #(
  parameter int DS1_WIN = 8192,
  parameter int DS1_THR = 9,
  parameter int E1_WIN  = 512,
  parameter int E1_THR  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_sel,
  input  logic mode_sel,
  input  logic din,
  input  logic rd_clr,
  input  logic mask,
  output logic ais,
  output logic delta,
  output logic irq
);
  import ais_det_pkg::*;

  trib_mode_e mode_cur;
  trib_mode_e mode_q;
  logic       restart;
  logic       is_e1;
  logic       rt_bit;
  logic       win_end;
  logic       win_enough;

  assign mode_cur = trib_mode_e'(mode_sel);
  assign restart  = (mode_cur != mode_q);
  assign is_e1    = (mode_cur == MODE_E1);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_DS1;
    else     mode_q <= mode_cur;
  end

  ais_retime u_rt (
    .clk      (clk),
    .rst      (rst),
    .edge_sel (edge_sel),
    .din      (din),
    .dout     (rt_bit)
  );

  ais_zwin #(
    .DS1_WIN (DS1_WIN),
    .DS1_THR (DS1_THR),
    .E1_WIN  (E1_WIN),
    .E1_THR  (E1_THR)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .e1         (is_e1),
    .restart    (restart),
    .rt_bit     (rt_bit),
    .win_end    (win_end),
    .win_enough (win_enough)
  );

  ais_judge u_jdg (
    .clk        (clk),
    .rst        (rst),
    .e1         (is_e1),
    .restart    (restart),
    .win_end    (win_end),
    .win_enough (win_enough),
    .ais        (ais)
  );

  ais_evt u_evt (
    .clk    (clk),
    .rst    (rst),
    .ais_in (ais),
    .rd_clr (rd_clr),
    .mask   (mask),
    .delta  (delta),
    .irq    (irq)
  );

  // R10: outputs are quiet right after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!ais && !delta && !irq));
endmodule

// File: tb/ais_det_top_tb_top.sv
`timescale 1ns/1ps
module ais_det_top_tb_top;
  localparam int DW = 1024;
  localparam int EW = 512;

  logic clk = 1'b0;
  logic rst, edge_sel, mode_sel, din, rd_clr, mask;
  logic ais, delta, irq;
  int   checks = 0;
  int   errors = 0;
  logic prev_ais = 1'b0;

  always #4 clk = ~clk;

  ais_det_top #(.DS1_WIN(DW), .DS1_THR(9), .E1_WIN(EW), .E1_THR(3)) dut_i (
    .clk(clk), .rst(rst), .edge_sel(edge_sel), .mode_sel(mode_sel),
    .din(din), .rd_clr(rd_clr), .mask(mask),
    .ais(ais), .delta(delta), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  // One window of len cycles with nz zeros centred in it.
  // clr_mode: 0 none, 1 strobe at i=64, 2 strobe in the cycle a status change is seen.
  task automatic win(input int len, input int nz, input bit narrow, input int clr_mode,
                     input logic exp_a, input bit chk_d, input logic exp_d,
                     input logic exp_i, input string tag_a, input string tag_d);
    for (int i = 0; i < len; i++) begin
      logic zero;
      @(posedge clk); #1;
      zero = (i >= len/2) && (i < len/2 + nz);
      rd_clr = ((clr_mode == 1) && (i == 64)) ||
               ((clr_mode == 2) && (ais !== prev_ais));
      prev_ais = ais;
      din = narrow ? 1'b1 : !zero;
      if (i == 32) begin
        chk(tag_a, ais, exp_a);
        if (chk_d) begin
          chk(tag_d, delta, exp_d);
          chk({tag_d, " irq"}, irq, exp_i);
        end
      end
      if (narrow && zero) begin
        #2 din = 1'b0;
        #3 din = 1'b1;
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; edge_sel = 1'b1; mode_sel = 1'b0; din = 1'b1;
    rd_clr = 1'b0; mask = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 ais in reset", ais, 1'b0);
    chk("R10 delta in reset", delta, 1'b0);
    chk("R10 irq in reset", irq, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_ds1_thresholds();
    win(DW, 20, 0, 0, 1'b0, 1, 1'b0, 1'b0, "R10 ais after reset", "R10 delta");
    win(DW, 8,  0, 0, 1'b0, 0, 1'b0, 1'b0, "R3 ais after 20 zeros", "");
    win(DW, 0,  0, 1, 1'b1, 1, 1'b1, 1'b1, "R2 set on 8 zeros", "R6 delta on set");
    win(DW, 9,  0, 0, 1'b1, 1, 1'b0, 1'b0, "R2 set on 0 zeros", "R6 delta cleared");
    win(DW, 30, 0, 0, 1'b0, 1, 1'b1, 1'b1, "R3 clear on 9 zeros", "R6 delta on clear");
  endtask

  task automatic t_mask_and_priority();
    mask = 1'b1;
    win(DW, 3,  0, 1, 1'b0, 1, 1'b1, 1'b0, "R3 stays clear", "R8 masked irq");
    win(DW, 30, 0, 1, 1'b1, 1, 1'b1, 1'b0, "R2 set on 3 zeros", "R8 masked new change");
    mask = 1'b0;
    win(DW, 30, 0, 2, 1'b0, 1, 1'b1, 1'b1, "R3 clear on 30 zeros", "R7 change beats clear");
  endtask

  task automatic t_edges();
    edge_sel = 1'b0;
    win(DW, 20, 1, 1, 1'b0, 0, 1'b0, 1'b0, "R3 still clear", "");
    win(DW, 20, 1, 0, 1'b0, 0, 1'b0, 1'b0, "R1 falling edge sees zeros", "");
    edge_sel = 1'b1;
    win(DW, 20, 1, 0, 1'b0, 0, 1'b0, 1'b0, "R1 falling zeros counted", "");
    win(DW, 20, 0, 0, 1'b1, 0, 1'b0, 1'b0, "R1 rising edge misses zeros", "");
  endtask

  task automatic t_e1_hysteresis();
    @(posedge clk); #1 mode_sel = 1'b1;
    win(EW, 2, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R9 ais kept over mode change", "");
    win(EW, 1, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R4 one low window", "");
    win(EW, 3, 0, 0, 1'b1, 0, 1'b0, 1'b0, "R4 two low windows", "");
    win(EW, 1, 0, 0, 1'b1, 0, 1'b0, 1'b0, "R5 one high window", "");
    win(EW, 3, 0, 0, 1'b1, 0, 1'b0, 1'b0, "R5 high after low", "");
    win(EW, 4, 0, 1, 1'b1, 0, 1'b0, 1'b0, "R5 first of two high", "");
    win(EW, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R5 two high windows", "");
  endtask

  task automatic t_mode_reset();
    @(posedge clk); #1 mode_sel = 1'b0;
    @(posedge clk); #1 mode_sel = 1'b1;
    win(EW, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R9 status after toggle", "");
    win(EW, 5, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R9 history discarded", "");
    win(EW, 5, 0, 0, 1'b0, 0, 1'b0, 1'b0, "R5 low then high", "");
  endtask

  initial begin
    t_reset();
    t_ds1_thresholds();
    t_mask_and_priority();
    t_edges();
    t_e1_hysteresis();
    t_mode_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule